// File: doc/BRIEF.md
# Two-wire slave for a current-DAC control register bank

This block is the serial control front end of a multi-channel current-output DAC. It listens to an I2C-compatible two-wire bus, which it samples with a faster system clock. It answers one of nine device addresses, chosen by two three-state select pins, and it keeps one 8-bit control byte for each output channel. Downstream channel logic reads those bytes directly. In each byte, bit 7 chooses sink (0) or source (1) and bits 4..0 set the magnitude.

A host sets a register by sending the device address with the write flag, then a register pointer, then one data byte. To read, the host first loads the pointer in the same way, then sends a repeated START (or a STOP and a new START) and addresses the device with the read flag. The block returns the selected byte and sends it again for as long as the host acknowledges. Any change on either address-select pin cancels the transfer in progress and releases SDA. The block drives SDA only as an open-drain pull-down enable.

Top module: `i2c_dac_ctrl`

## Requirements
- R1: After reset every channel byte on `ch_regs` is 00h and `sda_oe` is 0.
- R2: Each select pin takes a 2-bit code: 00 = tied low, 01 = tied high, 10 (or 11) = floating. The pair (sel_a1, sel_a0) picks the 8-bit write address 90h + 2k. The index k is 0..3 for (low,low), (low,high), (high,low), (high,high). It is 4..5 for (low or high, float) and 6..7 for (float, low or high), and it is 8 for (float,float). The slave acknowledges an address byte whose upper 7 bits match by holding SDA low through the ninth clock.
- R3: When the address byte does not match, the slave does not acknowledge it or any later byte, and it changes no register until the next START.
- R4: The sequence START, address with R/W = 0, pointer F8h + k, data, STOP gets three acknowledges. Channel k, shown on `ch_regs[8k+7:8k]`, then holds the data with bits 6 and 5 forced to 0.
- R5: If the pointer lies outside F8h..F8h+NCH-1, the pointer and data bytes are still acknowledged, but no channel byte changes.
- R6: After the pointer has been loaded, a read (address with R/W = 1) returns the addressed byte MSB first. Each bit is valid at the rising SCL edge. A pointer outside the channel range reads as 00h.
- R7: If the host acknowledges a read byte, the same byte is sent again. After a host NACK the slave leaves SDA released until the next START.
- R8: A change of either select code aborts the transfer. `sda_oe` drops within two clock cycles, and the rest of that transfer is neither acknowledged nor written.
- R9: A STOP ends the transfer. Bytes clocked after a STOP without a new START are not acknowledged.
- R10: The slave asserts `sda_oe` only while SCL is low, so every acknowledge and data bit it drives is settled before the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (bus wired-AND) |
| sel_a0 | input | 2 | Pre-decoded three-state code of select pin 0 |
| sel_a1 | input | 2 | Pre-decoded three-state code of select pin 1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ch_regs | output | 8*NCH | Control bytes, channel k in bits 8k+7..8k |

## Verification
Each bus event reaches the protocol state three system clocks after the line changes: two synchronizer stages, then the state register. A select-pin change reaches `sda_oe` after one or two clocks. The bench holds every SCL phase for ten clocks and samples SDA at the middle of the high phase. Each acknowledge, data bit and release is therefore read at least seven clocks after it falls due. Channel bytes and `sda_oe` are checked only after the STOP or the abort has had several idle clocks to settle. This keeps every comparison away from the edge where the value changes.

// File: rtl/i2cdac_pkg.sv
`timescale 1ns/1ps
package i2cdac_pkg;

    localparam logic [7:0] REG_BASE = 8'hF8;
    localparam logic [7:0] RSV_MASK = 8'h9F;
    localparam logic [6:0] DEV_BASE = 7'h48;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKW,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_PTR,
        BY_DATA
    } byte_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // code bit 1 set means floating; bit 0 gives the driven level
    function automatic logic [6:0] dev_addr(input logic [1:0] a1, input logic [1:0] a0);
        logic [3:0] idx;
        if (!a1[1] && !a0[1])
            idx = {2'b00, a1[0], a0[0]};
        else if (!a1[1])
            idx = 4'd4 + {3'b000, a1[0]};
        else if (!a0[1])
            idx = 4'd6 + {3'b000, a0[0]};
        else
            idx = 4'd8;
        return DEV_BASE + {3'b000, idx};
    endfunction

endpackage

// File: rtl/i2cdac_linesync.sv
`timescale 1ns/1ps
module i2cdac_linesync
    import i2cdac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_q, sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= scl_i;
                    sda_p <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= {scl_p[STAGES-2:0], scl_i};
                    sda_p <= {sda_p[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_p[TOP];
            sda_q <= sda_p[TOP];
        end
    end

    always_comb begin
        ev.scl   = scl_p[TOP];
        ev.sda   = sda_p[TOP];
        ev.rise  = scl_p[TOP] & ~scl_q;
        ev.fall  = ~scl_p[TOP] & scl_q;
        ev.start = scl_p[TOP] & scl_q & sda_q & ~sda_p[TOP];
        ev.stop  = scl_p[TOP] & scl_q & ~sda_q & sda_p[TOP];
    end

endmodule

// File: rtl/i2cdac_regbank.sv
`timescale 1ns/1ps
module i2cdac_regbank
    import i2cdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [7:0]       ptr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [8*NCH-1:0] ch_regs
);
    logic [7:0] regs_q [NCH];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            localparam logic [7:0] MY_PTR = 8'(int'(REG_BASE) + i);

            always_ff @(posedge clk) begin
                if (rst)
                    regs_q[i] <= 8'h00;
                else if (we && ptr == MY_PTR)
                    regs_q[i] <= wdata & RSV_MASK;
            end

            assign ch_regs[8*i +: 8] = regs_q[i];

            p_rsv_zero_r4: assert property (@(posedge clk) disable iff (rst)
                regs_q[i][6:5] == 2'b00);

            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                !$past(we) |-> $stable(regs_q[i]));

            p_reset_r1: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> regs_q[i] == 8'h00);
        end
    endgenerate

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NCH; i++)
            if (ptr == 8'(int'(REG_BASE) + i))
                rdata = regs_q[i];
    end

endmodule

// File: rtl/i2c_dac_ctrl.sv
`timescale 1ns/1ps
module i2c_dac_ctrl
    import i2cdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       sel_a0,
    input  logic [1:0]       sel_a1,
    output logic             sda_oe,
    output logic [8*NCH-1:0] ch_regs
);
    bus_ev_t    ev;
    st_e        st;
    byte_e      kind;
    logic [2:0] cnt;
    logic [7:0] sh, ptr, rdata, rxbyte;
    logic       rw, mack, we, sel_chg;
    logic [3:0] sel_q;
    logic [6:0] my_addr;

    i2cdac_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2cdac_regbank #(.NCH(NCH)) u_bank (
        .clk(clk), .rst(rst), .we(we), .ptr(ptr), .wdata(rxbyte),
        .rdata(rdata), .ch_regs(ch_regs)
    );

    assign my_addr = dev_addr(sel_a1, sel_a0);
    assign sel_chg = {sel_a1, sel_a0} != sel_q;
    assign rxbyte  = {sh[6:0], ev.sda};
    assign we      = !sel_chg && !ev.start && !ev.stop && st == ST_RX &&
                     kind == BY_DATA && ev.rise && cnt == 3'd7;
    assign sda_oe  = (st == ST_ACK) || (st == ST_TX && !sh[7]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            kind  <= BY_ADDR;
            cnt   <= 3'd0;
            sh    <= 8'h00;
            ptr   <= 8'h00;
            rw    <= 1'b0;
            mack  <= 1'b0;
            sel_q <= {sel_a1, sel_a0};
        end else begin
            sel_q <= {sel_a1, sel_a0};
            if (sel_chg || ev.stop) begin
                st <= ST_IDLE;
            end else if (ev.start) begin
                st   <= ST_RX;
                kind <= BY_ADDR;
                cnt  <= 3'd0;
            end else begin
                unique case (st)
                    ST_RX: if (ev.rise) begin
                        sh  <= rxbyte;
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            st <= ST_ACKW;
                            if (kind == BY_ADDR) begin
                                rw <= rxbyte[0];
                                if (rxbyte[7:1] != my_addr) st <= ST_IDLE;
                            end else if (kind == BY_PTR) begin
                                ptr <= rxbyte;
                            end
                        end
                    end
                    ST_ACKW: if (ev.fall) st <= ST_ACK;
                    ST_ACK: if (ev.fall) begin
                        cnt <= 3'd0;
                        if (kind == BY_ADDR && rw) begin
                            st <= ST_TX;
                            sh <= rdata;
                        end else if (kind == BY_ADDR) begin
                            st   <= ST_RX;
                            kind <= BY_PTR;
                        end else if (kind == BY_PTR) begin
                            st   <= ST_RX;
                            kind <= BY_DATA;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_TX: if (ev.fall) begin
                        sh  <= {sh[6:0], 1'b0};
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) st <= ST_MACK;
                    end
                    ST_MACK: begin
                        if (ev.rise) mack <= ~ev.sda;
                        if (ev.fall) begin
                            cnt <= 3'd0;
                            if (mack) begin
                                st <= ST_TX;
                                sh <= rdata;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    p_abort_release_r8: assert property (@(posedge clk) disable iff (rst)
        $past(sel_chg) |-> !sda_oe);

    p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
        $past(ev.stop) |-> !sda_oe);

    p_ack_match_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK && kind == BY_ADDR) |-> sh[7:1] == my_addr);

endmodule

// File: tb/sim_i2c_dac_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_dac_ctrl;
    localparam int NCH = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             scl = 1'b1;
    logic             sda_m = 1'b1;
    logic [1:0]       sel_a0 = 2'd2;
    logic [1:0]       sel_a1 = 2'd2;
    logic             sda_oe;
    logic [8*NCH-1:0] ch_regs;
    logic             sda_line;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_dac_ctrl #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sel_a0(sel_a0), .sel_a1(sel_a1), .sda_oe(sda_oe), .ch_regs(ch_regs)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; tick(10);
        sda_m = 1'b0; tick(10);
        scl = 1'b0; tick(10);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(10);
        scl = 1'b1; tick(10);
        sda_m = 1'b0; tick(10);
        scl = 1'b0; tick(10);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(10);
        scl = 1'b1; tick(10);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic send_bit(input logic b, output logic r);
        sda_m = b; tick(10);
        scl = 1'b1; tick(10);
        r = sda_line; tick(10);
        scl = 1'b0; tick(10);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) send_bit(d[i], r);
        send_bit(1'b1, ack);
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, r);
            d[i] = r;
        end
        send_bit(~give_ack, r);
    endtask

    task automatic wr3(input logic [7:0] dev, input logic [7:0] p, input logic [7:0] d,
                       output logic [2:0] acks);
        bus_start();
        wbyte(dev, acks[2]);
        wbyte(p, acks[1]);
        wbyte(d, acks[0]);
        bus_stop();
        tick(10);
    endtask

    task automatic rd1(input logic [7:0] dev, input logic [7:0] p, output logic [7:0] d);
        logic a;
        bus_start();
        wbyte(dev, a);
        wbyte(p, a);
        bus_rstart();
        wbyte(dev | 8'h01, a);
        rbyte(1'b0, d);
        bus_stop();
        tick(10);
    endtask

    function automatic logic [3:0] pins_of(input int k);
        logic [1:0] a1, a0;
        if (k < 4)      begin a1 = 2'(k >> 1); a0 = 2'(k & 1); end
        else if (k < 6) begin a1 = 2'(k - 4);  a0 = 2'd2;      end
        else if (k < 8) begin a1 = 2'd2;       a0 = 2'(k - 6); end
        else            begin a1 = 2'd2;       a0 = 2'd2;      end
        return {a1, a0};
    endfunction

    initial begin
        tick(200000 - 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0]  acks;
        logic        a;
        logic [7:0]  d, d2, d3;
        logic [31:0] snap;
        logic [7:0]  vals [NCH];

        vals[0] = 8'h92; vals[1] = 8'h7F; vals[2] = 8'hE5; vals[3] = 8'h0A;
        tick(5);
        rst = 1'b0;
        tick(5);
        chk("R1 ch_regs after reset", ch_regs, 32'h0);
        chk("R1 sda_oe after reset", {31'b0, sda_oe}, 32'h0);

        // R2 / R3: every pin setting against every candidate address
        for (int p = 0; p < 9; p++) begin
            {sel_a1, sel_a0} = pins_of(p);
            tick(10);
            for (int q = 0; q < 9; q++) begin
                bus_start();
                wbyte(8'(8'h90 + 2 * q), a);
                bus_stop();
                tick(5);
                chk(p == q ? "R2 address match ack" : "R3 address mismatch no ack",
                    {31'b0, a}, p == q ? 32'h0 : 32'h1);
            end
        end

        sel_a1 = 2'd2; sel_a0 = 2'd2;
        tick(10);

        // R4 / R6: write each channel then read it back
        for (int k = 0; k < NCH; k++) begin
            wr3(8'hA0, 8'(8'hF8 + k), vals[k], acks);
            chk("R4 write acks", {29'b0, acks}, 32'h0);
            chk("R4 channel byte", {24'b0, ch_regs[8*k +: 8]}, {24'b0, vals[k] & 8'h9F});
            rd1(8'hA0, 8'(8'hF8 + k), d);
            chk("R6 read back", {24'b0, d}, {24'b0, vals[k] & 8'h9F});
        end

        // R5: pointer out of range
        snap = ch_regs;
        wr3(8'hA0, 8'hF7, 8'h55, acks);
        chk("R5 out-of-range acks", {29'b0, acks}, 32'h0);
        wr3(8'hA0, 8'hFC, 8'hAA, acks);
        chk("R5 channels unchanged", ch_regs, snap);
        rd1(8'hA0, 8'hFC, d);
        chk("R6 out-of-range read", {24'b0, d}, 32'h0);

        // R3: wrong address with further bytes
        wr3(8'h92, 8'hF8, 8'h00, acks);
        chk("R3 no acks on foreign transfer", {29'b0, acks}, 32'h7);
        chk("R3 channels unchanged", ch_regs, snap);

        // R7: repeated bytes while acked, release after NACK
        wr3(8'hA0, 8'hF9, 8'h1F, acks);
        bus_start();
        wbyte(8'hA1, a);
        rbyte(1'b1, d);
        rbyte(1'b0, d2);
        rbyte(1'b0, d3);
        bus_stop();
        tick(10);
        chk("R7 first byte", {24'b0, d}, 32'h1F);
        chk("R7 repeated byte", {24'b0, d2}, 32'h1F);
        chk("R7 released after nack", {24'b0, d3}, 32'hFF);

        // R10: ack driven during SCL low before the ninth rise
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(1'(8'hA0 >> i), a);
        sda_m = 1'b1;
        tick(8);
        chk("R10 ack drive while scl low", {30'b0, scl, sda_oe}, 32'h1);
        scl = 1'b1; tick(10);
        chk("R10 ack held at high", {31'b0, sda_line}, 32'h0);
        scl = 1'b0; tick(10);
        bus_stop();
        tick(10);

        // R8: abort while slave drives a data bit
        bus_start();
        wbyte(8'hA1, a);
        chk("R8 slave driving before abort", {31'b0, sda_oe}, 32'h1);
        sel_a0 = 2'd0;
        tick(3);
        chk("R8 sda released after abort", {31'b0, sda_oe}, 32'h0);
        rbyte(1'b1, d);
        chk("R8 rest of read ignored", {24'b0, d}, 32'hFF);
        sel_a0 = 2'd2;
        bus_stop();
        tick(10);

        // R8: abort inside a data byte
        snap = ch_regs;
        bus_start();
        wbyte(8'hA0, a);
        wbyte(8'hF8, a);
        for (int i = 7; i >= 4; i--) send_bit(1'(8'h05 >> i), a);
        sel_a1 = 2'd0;
        tick(4);
        sel_a1 = 2'd2;
        tick(4);
        for (int i = 3; i >= 0; i--) send_bit(1'(8'h05 >> i), a);
        send_bit(1'b1, a);
        bus_stop();
        tick(10);
        chk("R8 aborted data not acked", {31'b0, a}, 32'h1);
        chk("R8 aborted data not written", ch_regs, snap);

        // R9: stop mid transfer, then bytes without a START
        bus_start();
        wbyte(8'hA0, a);
        bus_stop();
        tick(5);
        chk("R9 released after stop", {31'b0, sda_oe}, 32'h0);
        scl = 1'b0; tick(10);
        wbyte(8'hA0, a);
        chk("R9 no ack without start", {31'b0, a}, 32'h1);
        wbyte(8'hF8, a);
        wbyte(8'h00, a);
        scl = 1'b1; tick(10);
        chk("R9 channels unchanged", ch_regs, snap);
        wr3(8'hA0, 8'hFB, 8'h9F, acks);
        chk("R9 fresh transfer works", {24'b0, ch_regs[31:24]}, 32'h9F);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule